// File: doc/BRIEF.md
# Call Frame Builder

This block is the sequencer behind a procedure call. It takes the caller's stack pointer, argument pointer, frame pointer, return address and 16-bit status word, together with the 16-bit entry mask found at the called routine's entry point. From these it builds a call frame on the stack, one 32-bit longword at a time, through a write port that waits on a ready signal.

The stack pointer is first rounded down to a longword boundary. The general registers named in the mask are then pushed, followed by the three linkage values. Last comes one packed status longword. It records the two address bits that the rounding discarded, so that a later return can put them back. When the final write has been accepted, the block presents the new stack and frame pointers, the new argument pointer, the routine's first instruction address and the updated status word, and raises a one-cycle completion pulse.

Saved registers are read through a combinational register-file read port that the block addresses itself.

Top module: `cfb_frame_builder`

## Requirements
- R1: On `start` while idle, the block clears bits 1:0 of `sp_in` to form the working pointer. The first write goes to that aligned value minus 4.
- R2: Entry mask bits 11 to 0 are visited from bit 11 downward. Each set bit pushes the value that `rf_rd_data` returns for that register index, and each clear bit pushes nothing. Mask bits 15:12 cause no push.
- R3: After the saved registers, three values are pushed in this order: the captured `ap_in`, then `fp_in`, then `pc_in`.
- R4: `psw_out` equals the captured `psw_in` with these changes: bits 3:0 (N, Z, V, C) cleared, bit 5 (integer overflow trap enable) set to mask bit 14, and bit 7 (decimal overflow trap enable) set to mask bit 15. Every other bit is unchanged.
- R5: The last longword written is laid out as follows: bits 31:30 hold `sp_in[1:0]`, bits 29:28 are zero, bits 27:16 hold mask bits 11:0, and bits 15:0 hold `psw_in` with bit 4 (trace) cleared.
- R6: Every push first lowers the working pointer by 4 and then writes at the lowered address. `sp_out` is the aligned pointer minus 4 times (saved register count + 4).
- R7: At completion, `fp_out` equals `sp_out`, `ap_out` equals the captured `arg_addr`, and `pc_out` equals the captured `entry_addr` + 2.
- R8: While `mem_wr_valid` is high and `mem_wr_ready` is low, the write address and write data are held, and the frame does not advance.
- R9: `done` is high for exactly one cycle, in the cycle after the status longword is accepted. `start` and any input changes while the block is busy have no effect on the frame being built.
- R10: During reset and after it, before any `start`, `mem_wr_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame; only accepted when idle |
| sp_in | input | 32 | Caller stack pointer |
| fp_in | input | 32 | Caller frame pointer |
| ap_in | input | 32 | Caller argument pointer |
| pc_in | input | 32 | Return address |
| psw_in | input | 16 | Caller status word |
| entry_mask | input | 16 | Entry mask of the called routine |
| entry_addr | input | 32 | Address of the routine's entry mask |
| arg_addr | input | 32 | Argument list address for the callee |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data, combinational from index |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_addr | output | 32 | Write longword address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Write accepted when high together with valid |
| busy | output | 1 | Frame under construction |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | New stack pointer |
| fp_out | output | 32 | New frame pointer |
| ap_out | output | 32 | New argument pointer |
| pc_out | output | 32 | First instruction address of the callee |
| psw_out | output | 16 | Updated status word |

## Verification
The hold check on write data assumes that the register file does not change while a frame is being built, because the saved-register data passes straight through from `rf_rd_data`. The bench keeps its register array fixed during each frame and loads it only while the block is idle. The checks on the pointer step and the single-cycle pulse assume a frame is at least four pushes long, which the design always guarantees. The bench drives `start` only with sampled-stable timing, and it drives ready as always-high, pseudo-random, and mostly-low, so that stalls fall on every kind of push.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SAVE = 3'd1,
    S_AP   = 3'd2,
    S_FP   = 3'd3,
    S_PC   = 3'd4,
    S_STAT = 3'd5
  } cfb_state_t;

  // status word bit positions
  localparam int PSW_C_BIT   = 0;
  localparam int PSW_V_BIT   = 1;
  localparam int PSW_Z_BIT   = 2;
  localparam int PSW_N_BIT   = 3;
  localparam int PSW_T_BIT   = 4;
  localparam int PSW_IEN_BIT = 5;
  localparam int PSW_DEN_BIT = 7;

endpackage

// File: rtl/cfb_rst_sync.sv
module cfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cfb_mask_scan.sv
// Finds the highest pending register and the pending set with it removed.
module cfb_mask_scan #(
  parameter int NSAVE = 12,
  parameter int IDX_W = 4
) (
  input  logic [NSAVE-1:0] pend,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [NSAVE-1:0] pend_clr
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NSAVE; i++) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    pend_clr = pend;
    for (int j = 0; j < NSAVE; j++) begin
      if (found && (IDX_W'(j) == idx)) pend_clr[j] = 1'b0;
    end
  end
endmodule

// File: rtl/cfb_status_pack.sv
// Packs alignment bits, saved-register mask and status into the last pushed word,
// and forms the callee status word.
module cfb_status_pack
  import cfb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2,
  parameter int NSAVE   = 12,
  parameter int MASK_W  = 16,
  parameter int PSW_W   = 16
) (
  input  logic [ALIGN_W-1:0] sp_lo,
  input  logic [MASK_W-1:0]  mask,
  input  logic [PSW_W-1:0]   psw,
  output logic [DATA_W-1:0]  stat_word,
  output logic [PSW_W-1:0]   psw_new
);
  localparam int PAD_W = DATA_W - ALIGN_W - NSAVE - PSW_W;

  logic [PSW_W-1:0] psw_untraced;

  always_comb begin
    psw_untraced            = psw;
    psw_untraced[PSW_T_BIT] = 1'b0;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_word = {sp_lo, {PAD_W{1'b0}}, mask[NSAVE-1:0], psw_untraced};
    end else begin : g_nopad
      assign stat_word = {sp_lo, mask[NSAVE-1:0], psw_untraced};
    end
  endgenerate

  always_comb begin
    psw_new              = psw;
    psw_new[PSW_C_BIT]   = 1'b0;
    psw_new[PSW_V_BIT]   = 1'b0;
    psw_new[PSW_Z_BIT]   = 1'b0;
    psw_new[PSW_N_BIT]   = 1'b0;
    psw_new[PSW_IEN_BIT] = mask[MASK_W-2];
    psw_new[PSW_DEN_BIT] = mask[MASK_W-1];
  end
endmodule

// File: rtl/cfb_frame_builder.sv
module cfb_frame_builder
  import cfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = 16,
  parameter int NSAVE  = 12,
  parameter int PSW_W  = 16,
  localparam int IDX_W   = $clog2(NSAVE),
  localparam int BYTES   = DATA_W / 8,
  localparam int ALIGN_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] ap_in,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [MASK_W-1:0] entry_mask,
  input  logic [DATA_W-1:0] entry_addr,
  input  logic [DATA_W-1:0] arg_addr,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              mem_wr_valid,
  output logic [DATA_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] fp_out,
  output logic [DATA_W-1:0] ap_out,
  output logic [DATA_W-1:0] pc_out,
  output logic [PSW_W-1:0]  psw_out
);
  localparam logic [DATA_W-1:0] STEP     = DATA_W'(BYTES);
  localparam logic [DATA_W-1:0] PC_SKIP  = DATA_W'(2);

  logic rst_i_n;

  cfb_state_t state_q, state_d;
  logic [DATA_W-1:0]  sp_q, sp_d;
  logic [NSAVE-1:0]   pend_q, pend_d, pend_clr;
  logic               sp_en, pend_en, cap_en, fin;
  logic               scan_found;
  logic [IDX_W-1:0]   scan_idx;

  logic [DATA_W-1:0]  ap_q, fp_q, pc_q, entry_q, arg_q;
  logic [PSW_W-1:0]   psw_q;
  logic [MASK_W-1:0]  mask_q;
  logic [ALIGN_W-1:0] splo_q;

  logic               done_q;
  logic [DATA_W-1:0]  sp_out_q, fp_out_q, ap_out_q, pc_out_q;
  logic [PSW_W-1:0]   psw_out_q;

  logic [DATA_W-1:0]  push_addr, stat_word, wr_data;
  logic [PSW_W-1:0]   psw_new;
  logic               acc;

  cfb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfb_mask_scan #(.NSAVE(NSAVE), .IDX_W(IDX_W)) u_scan (
    .pend     (pend_q),
    .found    (scan_found),
    .idx      (scan_idx),
    .pend_clr (pend_clr)
  );

  cfb_status_pack #(
    .DATA_W (DATA_W), .ALIGN_W(ALIGN_W), .NSAVE(NSAVE),
    .MASK_W (MASK_W), .PSW_W  (PSW_W)
  ) u_pack (
    .sp_lo     (splo_q),
    .mask      (mask_q),
    .psw       (psw_q),
    .stat_word (stat_word),
    .psw_new   (psw_new)
  );

  assign push_addr    = sp_q - STEP;
  assign mem_wr_valid = (state_q != S_IDLE);
  assign acc          = mem_wr_valid && mem_wr_ready;
  assign cap_en       = (state_q == S_IDLE) && start;

  always_comb begin
    case (state_q)
      S_SAVE:  wr_data = rf_rd_data;
      S_AP:    wr_data = ap_q;
      S_FP:    wr_data = fp_q;
      S_PC:    wr_data = pc_q;
      S_STAT:  wr_data = stat_word;
      default: wr_data = '0;
    endcase
  end

  // next-state
  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    pend_d  = pend_q;
    sp_en   = 1'b0;
    pend_en = 1'b0;
    fin     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          sp_d    = {sp_in[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
          sp_en   = 1'b1;
          pend_d  = entry_mask[NSAVE-1:0];
          pend_en = 1'b1;
          state_d = (|entry_mask[NSAVE-1:0]) ? S_SAVE : S_AP;
        end
      end
      S_SAVE: begin
        if (acc) begin
          sp_d    = push_addr;
          sp_en   = 1'b1;
          pend_d  = pend_clr;
          pend_en = 1'b1;
          if (pend_clr == '0) state_d = S_AP;
        end
      end
      S_AP: if (acc) begin sp_d = push_addr; sp_en = 1'b1; state_d = S_FP;   end
      S_FP: if (acc) begin sp_d = push_addr; sp_en = 1'b1; state_d = S_PC;   end
      S_PC: if (acc) begin sp_d = push_addr; sp_en = 1'b1; state_d = S_STAT; end
      S_STAT: begin
        if (acc) begin
          sp_d    = push_addr;
          sp_en   = 1'b1;
          fin     = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  // working pointer and pending set
  always_ff @(posedge clk) begin
    if (sp_en)   sp_q   <= sp_d;
    if (pend_en) pend_q <= pend_d;
  end

  // captured call operands
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ap_q    <= ap_in;
      fp_q    <= fp_in;
      pc_q    <= pc_in;
      psw_q   <= psw_in;
      mask_q  <= entry_mask;
      entry_q <= entry_addr;
      arg_q   <= arg_addr;
      splo_q  <= sp_in[ALIGN_W-1:0];
    end
  end

  // completion results
  always_ff @(posedge clk) begin
    if (fin) begin
      sp_out_q  <= push_addr;
      fp_out_q  <= push_addr;
      ap_out_q  <= arg_q;
      pc_out_q  <= entry_q + PC_SKIP;
      psw_out_q <= psw_new;
    end
  end

  assign rf_rd_idx   = scan_idx;
  assign mem_wr_addr = push_addr;
  assign mem_wr_data = wr_data;
  assign busy        = mem_wr_valid;
  assign done        = done_q;
  assign sp_out      = sp_out_q;
  assign fp_out      = fp_out_q;
  assign ap_out      = ap_out_q;
  assign pc_out      = pc_out_q;
  assign psw_out     = psw_out_q;

endmodule

// File: rtl/cfb_frame_builder_chk.sv
module cfb_frame_builder_chk #(
  parameter int DATA_W = 32,
  parameter int PSW_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [DATA_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              done,
  input logic [DATA_W-1:0] sp_out,
  input logic [DATA_W-1:0] fp_out,
  input logic [PSW_W-1:0]  psw_out
);
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00));  // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));  // R8

  AST_PREDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready) |=>
      (!mem_wr_valid || (mem_wr_addr == $past(mem_wr_addr) - 32'd4)));  // R6

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_wr_valid && mem_wr_ready));  // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_wr_valid);  // R9

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (psw_out[3:0] == 4'b0000));  // R4

  AST_FP_IS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fp_out == sp_out) && (sp_out[1:0] == 2'b00)));  // R7
endmodule

bind cfb_frame_builder cfb_frame_builder_chk #(.DATA_W(DATA_W), .PSW_W(PSW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .done         (done),
  .sp_out       (sp_out),
  .fp_out       (fp_out),
  .psw_out      (psw_out)
);

// File: tb/cfb_frame_builder_bench.sv
module cfb_frame_builder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] sp_in = '0, fp_in = '0, ap_in = '0, pc_in = '0;
  logic [15:0] psw_in = '0, entry_mask = '0;
  logic [31:0] entry_addr = '0, arg_addr = '0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        mem_wr_ready = 1'b0;
  logic        busy, done;
  logic [31:0] sp_out, fp_out, ap_out, pc_out;
  logic [15:0] psw_out;

  logic [31:0] rf [0:15];
  assign rf_rd_data = rf[rf_rd_idx];

  always #5 clk = ~clk;

  cfb_frame_builder u_cfb_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sp_in(sp_in), .fp_in(fp_in), .ap_in(ap_in), .pc_in(pc_in),
    .psw_in(psw_in), .entry_mask(entry_mask), .entry_addr(entry_addr),
    .arg_addr(arg_addr), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
    .busy(busy), .done(done), .sp_out(sp_out), .fp_out(fp_out),
    .ap_out(ap_out), .pc_out(pc_out), .psw_out(psw_out)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } wr_t;

  wr_t         q[$];
  bit          exp_done = 1'b0;
  logic [31:0] x_sp, x_ap, x_pc;
  logic [15:0] x_psw;
  int          frames = 0;
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference frame: built from requirements R1..R7
  task automatic build_frame();
    logic [31:0] sp;
    logic [15:0] p;
    wr_t w;
    sp = {sp_in[31:2], 2'b00};
    for (int i = 11; i >= 0; i--) begin
      if (entry_mask[i]) begin
        sp = sp - 4; w.addr = sp; w.data = rf[i];
        w.tag = (q.size() == 0) ? "R1" : "R2"; q.push_back(w);
      end
    end
    sp = sp - 4; w.addr = sp; w.data = ap_in; w.tag = (q.size()==0) ? "R1" : "R3"; q.push_back(w);
    sp = sp - 4; w.addr = sp; w.data = fp_in; w.tag = "R3"; q.push_back(w);
    sp = sp - 4; w.addr = sp; w.data = pc_in; w.tag = "R3"; q.push_back(w);
    p = psw_in; p[4] = 1'b0;
    sp = sp - 4; w.addr = sp; w.data = {sp_in[1:0], 2'b00, entry_mask[11:0], p};
    w.tag = "R5"; q.push_back(w);
    x_sp = sp; x_ap = arg_addr; x_pc = entry_addr + 2;
    x_psw = psw_in; x_psw[3:0] = 4'b0; x_psw[5] = entry_mask[14]; x_psw[7] = entry_mask[15];
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_done = 1'b0;
      chk(!mem_wr_valid && !busy && !done, "R10 reset outputs",
          {29'b0, mem_wr_valid, busy, done}, 32'd0);
    end else begin
      bit nd;
      chk(mem_wr_valid == (q.size() > 0), "R8 write valid", 32'(mem_wr_valid), 32'(q.size() > 0));
      chk(busy == (q.size() > 0), "R10 busy", 32'(busy), 32'(q.size() > 0));
      if (mem_wr_valid && q.size() > 0) begin
        chk(mem_wr_addr == q[0].addr, {q[0].tag, " R6 write address"}, mem_wr_addr, q[0].addr);
        chk(mem_wr_data == q[0].data, {q[0].tag, " write data"}, mem_wr_data, q[0].data);
      end
      chk(done == exp_done, "R9 done pulse", 32'(done), 32'(exp_done));
      if (exp_done) begin
        chk(sp_out == x_sp, "R6 sp_out", sp_out, x_sp);
        chk(fp_out == x_sp, "R7 fp_out", fp_out, x_sp);
        chk(ap_out == x_ap, "R7 ap_out", ap_out, x_ap);
        chk(pc_out == x_pc, "R7 pc_out", pc_out, x_pc);
        chk(psw_out == x_psw, "R4 psw_out", 32'(psw_out), 32'(x_psw));
        frames++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0:       mem_wr_ready = 1'b1;
        1:       mem_wr_ready = lfsr[0];
        default: mem_wr_ready = (lfsr[1:0] == 2'b00);
      endcase
      nd = 1'b0;
      if (q.size() > 0) begin
        if (mem_wr_ready) begin
          if (q.size() == 1) nd = 1'b1;
          void'(q.pop_front());
        end
      end else if (start) begin
        build_frame();
      end
      exp_done = nd;
    end
  end

  task automatic set_call(input logic [31:0] sp, input logic [15:0] mask,
                          input logic [15:0] psw, input int seed);
    sp_in = sp; entry_mask = mask; psw_in = psw;
    fp_in = 32'h7000_0000 + 32'(seed); ap_in = 32'h6000_0000 + 32'(seed * 3);
    pc_in = 32'h0040_1000 + 32'(seed * 5);
    entry_addr = 32'h0002_0000 + 32'(seed * 16); arg_addr = 32'h0005_0000 + 32'(seed * 8);
  endtask

  task automatic run_frame(input int mode);
    int f0;
    f0 = frames;
    ready_mode = mode;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (frames == f0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'hA000_0000 + 32'(i * 32'h0101_0101);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    // R10: idle after reset
    chk(!mem_wr_valid && !busy && !done, "R10 idle after reset",
        {29'b0, mem_wr_valid, busy, done}, 32'd0);

    // R1 R3 R5: empty mask, aligned pointer
    set_call(32'h0001_0000, 16'h0000, 16'h001F, 1);
    run_frame(0);
    // R2 R1: all registers, pointer low bits 3
    set_call(32'h0002_0003, 16'h0FFF, 16'h00A5, 2);
    run_frame(1);
    // R4 R8: trap enables, heavy stalls, low bits 1
    set_call(32'h0003_1001, 16'hC0A5, 16'hFF5A, 3);
    run_frame(2);
    // R2: mask bits 15:12 push nothing
    set_call(32'h0004_0002, 16'h7801, 16'h0010, 4);
    run_frame(1);

    // R9: start and input changes while busy are ignored
    for (int i = 0; i < 16; i++) rf[i] = 32'h5000_0000 ^ 32'(i * 32'h0011_0003);
    begin
      int f0;
      f0 = frames;
      set_call(32'h0005_0000, 16'h0F0F, 16'h0080, 5);
      ready_mode = 2;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (3) @(posedge clk);
      #1 set_call(32'h0099_0007, 16'h8FFF, 16'h1234, 9);
      start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      while (frames == f0) @(posedge clk);
      repeat (4) @(posedge clk);
      #1 chk(!mem_wr_valid, "R9 no second frame", 32'(mem_wr_valid), 32'd0);
    end

    // R6: single register, random ready
    set_call(32'h0006_0004, 16'h0800, 16'h0000, 6);
    run_frame(1);

    chk(frames == 6, "R9 frame count", 32'(frames), 32'd6);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", frames, 6);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule